// File: doc/BRIEF.md
# Single-Bit Sector Parity Corrector

This block checks one data sector against a 24-bit parity code kept in the spare area. It repairs the sector when a single data bit has flipped. The sector is loaded byte by byte into an internal RAM. A start strobe then presents two values: the 32-bit raw parity word produced by an external accumulator over that sector, and the 24-bit code read back from flash. The block compresses the raw word into a 24-bit code by dropping its two reserved nibbles, then inverts it, so an erased sector of all ones matches an erased spare area. It XORs the result with the stored code and decodes that difference.

A clean difference, a flipped bit inside the stored code, and a pattern that cannot be repaired each finish in one evaluation cycle. A repairable data error takes one more cycle for a read-modify-write that toggles the addressed bit in the RAM. Software then reads the repaired sector through a registered read port. Each run ends with a one-cycle done pulse and a two-bit status that holds until the next run completes.

Top module: `sector_ecc_fix`

## Requirements
- R1: While reset is active and right after it is released, busy_o and done_o are low and status_o is 00.
- R2: When a start is accepted, code_o takes the value ~{raw_par_i[27:16], raw_par_i[11:0]} and holds it until the next accepted start. Bits 31:28 and 15:12 of raw_par_i have no effect. code_o[7:0] is the byte stored first, then [15:8], then [23:16].
- R3: If the difference (code_o XOR stored_code_i) is zero, status is 00 (clean) and the sector is unchanged. A raw word of zero with a stored code of 0xFFFFFF counts as clean.
- R4: If bits 23:12 of the difference XOR bits 11:0 equal 0xFFF and the byte index (difference bits 23:15) is below SECT_BYTES, the block toggles bit (difference bits 14:12) of that byte and reports status 01.
- R5: A difference of the R4 form whose byte index is SECT_BYTES or more is reported as 11 (uncorrectable), and no byte changes.
- R6: A difference with exactly one bit set is reported as 10 (error in the stored code), and no byte changes.
- R7: Any other nonzero difference is reported as 11, and no byte changes.
- R8: done_o is a one-cycle pulse. status_o changes only in a cycle where done_o is high and otherwise holds.
- R9: busy_o rises in the cycle after an accepted start and falls in the cycle where done_o rises. While busy_o is high, start_i and wr_en_i are ignored.
- R10: With busy_o low, wr_en_i writes wr_data_i to byte wr_addr_i, and rd_data_o shows byte rd_addr_i one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one check, accepted only when idle |
| raw_par_i | input | 32 | Raw parity word from the accumulator |
| stored_code_i | input | 24 | Code read from the spare area, first byte in [7:0] |
| wr_en_i | input | 1 | Sector byte write strobe |
| wr_addr_i | input | 9 | Sector byte write address |
| wr_data_i | input | 8 | Sector byte write data |
| rd_addr_i | input | 9 | Sector byte read address |
| rd_data_o | output | 8 | Sector byte read data, one cycle latency |
| code_o | output | 24 | Packed, inverted code from the last accepted start |
| busy_o | output | 1 | Check or repair in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 2 | 00 clean, 01 data bit fixed, 10 code bit in error, 11 uncorrectable |

## Verification
The hardest case to reach is a difference that has the repairable two-half form but points past the end of the sector. At the default depth of 512 the nine-bit byte index can never go out of range. The bench therefore builds the block with a 448-byte sector and forms the stored code as the packed code XOR {p, ~p}, with p chosen beyond the last byte. A start and a write strobe are also driven in the middle of a repair, to show that the busy window ignores both.

// File: rtl/secc_pkg.sv
package secc_pkg;
  localparam int RAW_W  = 32;
  localparam int HALF_W = 12;
  localparam int CODE_W = 2 * HALF_W;
  localparam int LO_POS = 0;
  localparam int HI_POS = 16;
  localparam int BIT_W  = 3;
  localparam int IDX_W  = CODE_W - HALF_W - BIT_W;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_DATA  = 2'b01,
    ST_CODE  = 2'b10,
    ST_BAD   = 2'b11
  } ecc_status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_EVAL,
    S_WB
  } fix_fsm_e;
endpackage

// File: rtl/secc_code_pack.sv
module secc_code_pack
  import secc_pkg::*;
(
  input  logic [RAW_W-1:0]  raw_i,
  output logic [CODE_W-1:0] code_o
);
  logic unused_rsv;
  assign unused_rsv = ^{raw_i[RAW_W-1:HI_POS+HALF_W], raw_i[HI_POS-1:LO_POS+HALF_W]};

  // invert so an erased sector matches an erased spare area
  assign code_o = ~{raw_i[HI_POS +: HALF_W], raw_i[LO_POS +: HALF_W]};
endmodule

// File: rtl/secc_classify.sv
module secc_classify
  import secc_pkg::*;
#(
  parameter int SECT_BYTES = 512
) (
  input  logic [CODE_W-1:0] diff_i,
  output ecc_status_e       kind_o,
  output logic [IDX_W-1:0]  byte_idx_o,
  output logic [BIT_W-1:0]  bit_idx_o
);
  logic [HALF_W-1:0] lo_half, hi_half;
  logic              pair_ok, single, in_range;

  assign lo_half    = diff_i[HALF_W-1:0];
  assign hi_half    = diff_i[CODE_W-1:HALF_W];
  assign pair_ok    = (hi_half ^ lo_half) == {HALF_W{1'b1}};
  assign single     = $onehot(diff_i);
  assign bit_idx_o  = diff_i[HALF_W +: BIT_W];
  assign byte_idx_o = diff_i[CODE_W-1 -: IDX_W];
  assign in_range   = 32'(byte_idx_o) < SECT_BYTES;

  always_comb begin
    if (diff_i == '0)      kind_o = ST_CLEAN;
    else if (pair_ok)      kind_o = in_range ? ST_DATA : ST_BAD;
    else if (single)       kind_o = ST_CODE;
    else                   kind_o = ST_BAD;
  end
endmodule

// File: rtl/secc_sector_ram.sv
module secc_sector_ram #(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/sector_ecc_fix.sv
module sector_ecc_fix
  import secc_pkg::*;
#(
  parameter int SECT_BYTES = 512,
  parameter int DATA_W     = 8,
  localparam int AW        = $clog2(SECT_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RAW_W-1:0]  raw_par_i,
  input  logic [CODE_W-1:0] stored_code_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CODE_W-1:0] code_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        status_o
);
  fix_fsm_e          state_q;
  logic [CODE_W-1:0] diff_q, code_q, calc_code;
  ecc_status_e       status_q, kind;
  logic              done_q;
  logic [IDX_W-1:0]  byte_idx;
  logic [BIT_W-1:0]  bit_idx;
  logic [AW-1:0]     fix_addr;
  logic [DATA_W-1:0] ram_rdata, flip_mask;
  logic              ram_we, wr_ok;
  logic [AW-1:0]     ram_waddr, ram_raddr;
  logic [DATA_W-1:0] ram_wdata;

  secc_code_pack u_pack (
    .raw_i  (raw_par_i),
    .code_o (calc_code)
  );

  secc_classify #(.SECT_BYTES(SECT_BYTES)) u_classify (
    .diff_i     (diff_q),
    .kind_o     (kind),
    .byte_idx_o (byte_idx),
    .bit_idx_o  (bit_idx)
  );

  assign fix_addr  = AW'(byte_idx);
  assign flip_mask = DATA_W'(1) << bit_idx;
  assign wr_ok     = wr_en_i && (32'(wr_addr_i) < SECT_BYTES);

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = wr_addr_i;
    ram_wdata = wr_data_i;
    ram_raddr = rd_addr_i;
    unique case (state_q)
      S_IDLE: ram_we = wr_ok;
      S_EVAL: ram_raddr = fix_addr;
      S_WB: begin
        ram_we    = 1'b1;
        ram_waddr = fix_addr;
        ram_wdata = ram_rdata ^ flip_mask;
        ram_raddr = fix_addr;
      end
      default: ;
    endcase
  end

  secc_sector_ram #(.DEPTH(SECT_BYTES), .DATA_W(DATA_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (ram_raddr),
    .rdata_o (ram_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      diff_q   <= '0;
      code_q   <= '0;
      status_q <= ST_CLEAN;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          code_q  <= calc_code;
          diff_q  <= calc_code ^ stored_code_i;
          state_q <= S_EVAL;
        end
        S_EVAL: begin
          if (kind == ST_DATA) begin
            state_q <= S_WB;
          end else begin
            status_q <= kind;
            done_q   <= 1'b1;
            state_q  <= S_IDLE;
          end
        end
        S_WB: begin
          status_q <= ST_DATA;
          done_q   <= 1'b1;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_data_o = ram_rdata;
  assign code_o    = code_q;
  assign busy_o    = state_q != S_IDLE;
  assign done_o    = done_q;
  assign status_o  = status_q;
endmodule

// File: rtl/sector_ecc_fix_chk.sv
module sector_ecc_fix_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] status_o
);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_status_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(status_o));

  a_r9_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r9_busy_ends_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r9_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r4_fix_two_cycles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && status_o == 2'b01) |-> $past(busy_o, 2));
endmodule

bind sector_ecc_fix sector_ecc_fix_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .status_o (status_o)
);

// File: tb/sector_ecc_fix_bench.sv
module sector_ecc_fix_bench;
  localparam int SB = 448;
  localparam int AW = $clog2(SB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [31:0]   raw_par_i = '0;
  logic [23:0]   stored_code_i = '0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [7:0]    wr_data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [7:0]    rd_data_o;
  logic [23:0]   code_o;
  logic          busy_o, done_o;
  logic [1:0]    status_o;

  always #2 clk = ~clk;

  sector_ecc_fix #(.SECT_BYTES(SB)) u_sector_ecc_fix (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .raw_par_i(raw_par_i),
    .stored_code_i(stored_code_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .code_o(code_o), .busy_o(busy_o), .done_o(done_o), .status_o(status_o)
  );

  typedef struct {
    logic [1:0]  st;
    logic [23:0] code;
    string       req;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] model [SB];
  int n_chk = 0, n_bad = 0, n_done = 0;

  function automatic logic [23:0] ref_code(logic [31:0] r);
    return ~{r[27:16], r[11:0]};
  endfunction

  function automatic logic [23:0] pair_diff(int byte_n, int bit_n);
    logic [11:0] p;
    p = 12'(byte_n * 8 + bit_n);
    return {p, ~p};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop one expected result per done pulse
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      n_done++;
      if (sb_q.size() == 0) begin
        chk("R9 unexpected done", 32'(status_o), 32'hDEAD);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.req, 32'(status_o), 32'(e.st));
        chk("R2 code", 32'(code_o), 32'(e.code));
      end
    end
  end

  task automatic run_op(logic [31:0] raw, logic [23:0] diff, logic [1:0] st, string req);
    int k;
    @(negedge clk);
    start_i       = 1'b1;
    raw_par_i     = raw;
    stored_code_i = ref_code(raw) ^ diff;
    sb_q.push_back('{st, ref_code(raw), req});
    k = n_done;
    @(negedge clk);
    start_i = 1'b0;
    while (n_done == k) @(negedge clk);
  endtask

  task automatic read_byte(int a, output logic [7:0] v);
    @(negedge clk);
    rd_addr_i = AW'(a);
    @(negedge clk);
    v = rd_data_o;
  endtask

  task automatic verify_all(string req);
    logic [7:0] v;
    for (int i = 0; i < SB; i++) begin
      read_byte(i, v);
      chk(req, 32'(v), 32'(model[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int k;
    repeat (3) @(negedge clk);
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 status", 32'(status_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after release", 32'(busy_o), 0);
    chk("R1 status after release", 32'(status_o), 0);

    // R10 fill and read back
    for (int i = 0; i < SB; i++) begin
      @(negedge clk);
      wr_en_i   = 1'b1;
      wr_addr_i = AW'(i);
      wr_data_i = 8'(i * 37 + 11);
      model[i]  = 8'(i * 37 + 11);
    end
    @(negedge clk);
    wr_en_i = 1'b0;
    verify_all("R10 readback");

    // R3 clean, R2 reserved nibbles ignored
    run_op(32'h1234_5678, 24'h0, 2'b00, "R3 clean");
    run_op(32'hF000_F000, 24'h0, 2'b00, "R3 erased");
    @(negedge clk);
    chk("R3 erased code", 32'(code_o), 32'h00FF_FFFF);
    run_op(32'h0ABC_0DEF, 24'h0, 2'b00, "R2 fresh code");
    verify_all("R3 unchanged");

    // R4 data bit repairs
    run_op(32'h0ABC_0DEF, pair_diff(100, 5), 2'b01, "R4 fix 100.5");
    model[100] ^= 8'h20;
    read_byte(100, v);
    chk("R4 byte 100", 32'(v), 32'(model[100]));
    run_op(32'hA5A5_A5A5, pair_diff(0, 0), 2'b01, "R4 fix 0.0");
    model[0] ^= 8'h01;
    run_op(32'h5A5A_5A5A, pair_diff(SB - 1, 7), 2'b01, "R4 fix last.7");
    model[SB-1] ^= 8'h80;
    verify_all("R4 sector");

    // R5 index past sector
    run_op(32'h1111_2222, pair_diff(450, 2), 2'b11, "R5 out of range");
    run_op(32'h3333_4444, pair_diff(511, 7), 2'b11, "R5 max index");
    verify_all("R5 unchanged");

    // R6 single bit in stored code
    run_op(32'h0F0F_0F0F, 24'h10_0000, 2'b10, "R6 code bit 20");
    run_op(32'h7777_8888, 24'h00_0001, 2'b10, "R6 code bit 0");
    verify_all("R6 unchanged");

    // R7 other patterns
    run_op(32'h2468_ACE0, 24'h00_0003, 2'b11, "R7 two bits");
    run_op(32'h1357_9BDF, pair_diff(10, 1) ^ 24'h00_0100, 2'b11, "R7 broken pair");
    verify_all("R7 unchanged");

    // R9 start and write ignored during a repair
    @(negedge clk);
    start_i       = 1'b1;
    raw_par_i     = 32'hCAFE_F00D;
    stored_code_i = ref_code(32'hCAFE_F00D) ^ pair_diff(200, 1);
    sb_q.push_back('{2'b01, ref_code(32'hCAFE_F00D), "R9 fix during busy"});
    k = n_done;
    @(negedge clk);
    chk("R9 busy after start", 32'(busy_o), 1);
    raw_par_i = 32'h0000_0000;
    wr_en_i   = 1'b1;
    wr_addr_i = AW'(200);
    wr_data_i = 8'h00;
    @(negedge clk);
    start_i = 1'b0;
    wr_en_i = 1'b0;
    while (n_done == k) @(negedge clk);
    model[200] ^= 8'h02;
    repeat (4) @(negedge clk);
    chk("R9 no second run", 32'(n_done), 32'(k + 1));
    read_byte(200, v);
    chk("R9 write ignored", 32'(v), 32'(model[200]));

    // R8 status holds after pulse
    chk("R8 status hold", 32'(status_o), 32'h1);
    chk("R8 done low", 32'(done_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule